// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block drives an external 14-bit successive-approximation converter whose result comes out on a byte-wide three-state bus. A one-cycle start request makes the block run the whole transaction on the converter's control pins. It drops chip-select three times. At each of those falling edges the read/convert line carries the level that the converter expects.

The first falling edge wakes the converter and opens acquisition. The second closes acquisition and starts the internally clocked conversion. The third falling edge comes only after end-of-conversion has gone low, and it opens the read. The block then reads the upper byte and the lower byte by toggling the byte-select output. It packs the two bytes into a zero-extended word and announces that word with a single-cycle strobe.

A mode input chooses the power state the converter drops into after the conversion: standby or shutdown. When the last conversion ended in shutdown, or when the converter's state is unknown after reset or after a timeout, the block stretches the acquisition gap to a reference wake-up time. If end-of-conversion never arrives, a timeout returns the block to idle and raises an error flag. All timings are parameters in system clock cycles. Their defaults are derived from the clock frequency.

Top module: `adc_host_seq`

## Requirements
- R1: After reset and whenever busy_o is low, cs_n_o is high, and busy_o, valid_o and hben_o are low. err_o is low after reset.
- R2: At the first chip-select falling edge of a transaction, rc_o is 0.
- R3: At the second chip-select falling edge, rc_o equals the value of shutdown_i captured with the start request (1 = shutdown after conversion, 0 = standby).
- R4: When the previous conversion ended in shutdown, or no conversion has completed since reset or since a timeout, the gap from the first to the second falling edge is at least WAKE_CYC clock cycles.
- R5: When the previous conversion ended in standby, that gap is CSL_CYC + ACQ_CYC cycles, with no wake-up wait.
- R6: The third chip-select falling edge happens only after the synchronized eoc_n_i has been seen low, and rc_o is 1 at that edge.
- R7: hben_o is 1 at the third falling edge, and the upper byte is read first. hben_o then goes to 0 for the lower byte. result_o is {2'b00, upper[5:0], lower[7:0]}, so upper bus bits 7:6 are discarded.
- R8: valid_o is high for exactly one cycle per conversion. busy_o is high from the cycle after start_i is accepted through the valid_o cycle, and low the cycle after.
- R9: If eoc_n_i is not seen low within EOC_TMO_CYC cycles after the second edge's low phase ends, err_o goes high, the block returns to idle with cs_n_o high, and no valid_o is produced. err_o clears on the next accepted start.
- R10: start_i while busy_o is high is ignored: each transaction makes exactly three chip-select falling edges and one valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| shutdown_i | input | 1 | Power mode after conversion: 1 shutdown, 0 standby |
| eoc_n_i | input | 1 | End-of-conversion from the converter, active low |
| data_i | input | BUS_W (8) | Converter data bus |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| rc_o | output | 1 | Read/convert control level |
| hben_o | output | 1 | Byte select: 1 upper byte, 0 lower byte |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle strobe marking result_o |
| err_o | output | 1 | End-of-conversion timeout flag |
| result_o | output | OUT_W (16) | Zero-extended conversion result |

## Verification
The bound checker watches a number of behaviours on every cycle:
- the control levels at each counted chip-select falling edge;
- the minimum wake-up gap after a shutdown-ended or unknown power state;
- the single-cycle valid strobe and its inclusion in busy;
- the cleared upper result bits;
- the idle state of chip-select after a timeout.

Other behaviours can only be shown by the bench's scenarios against its converter model, because they need a chosen stimulus and a known expected value:
- the exact assembled result values;
- the short standby gap;
- the read edge coming after end-of-conversion;
- the timeout path when end-of-conversion is withheld;
- start requests being ignored while a transaction runs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAKE_LO,
      ST_ACQ,
      ST_CONV_LO,
      ST_CONV_WAIT,
      ST_RD_SETUP,
      ST_RD_HI,
      ST_RD_LO,
      ST_DONE
   } seq_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int        WIDTH   = 1,
   parameter int        STAGES  = 2,
   parameter logic      RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_seq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= {WIDTH{RST_VAL}};
         end else begin
            if (s == 0) begin
               stage_q[s] <= d_i;
            end else begin
               stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          expired_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_pack.sv
module adc_seq_pack #(
   parameter int BUS_W = 8,
   parameter int RES_W = 14,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_hi_i,
   input  logic             cap_lo_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic [OUT_W-1:0] word_o
);

   localparam int HI_W  = RES_W - BUS_W;
   localparam int PAD_W = OUT_W - RES_W;

   if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_split
      $error("adc_seq_pack: RES_W must lie in (BUS_W, 2*BUS_W]");
   end

   logic [HI_W-1:0]  hi_q;
   logic [BUS_W-1:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (cap_hi_i) hi_q <= bus_i[HI_W-1:0];
         if (cap_lo_i) lo_q <= bus_i;
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, hi_q, lo_q};
   end else begin : g_nopad
      assign word_o = {hi_q, lo_q};
   end

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
   import adc_seq_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BUS_W       = 8,
   parameter int RES_W       = 14,
   parameter int OUT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_CYC    = (CLK_HZ / 1000) * 12,
   parameter int ACQ_CYC     = (CLK_HZ / 1_000_000) * 2,
   parameter int CSL_CYC     = CLK_HZ / 20_000_000 + 1,
   parameter int CSH_CYC     = CLK_HZ / 20_000_000 + 1,
   parameter int DV_CYC      = CLK_HZ / 10_000_000 + 1,
   parameter int EOC_TMO_CYC = (CLK_HZ / 1_000_000) * 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             shutdown_i,
   input  logic             eoc_n_i,
   input  logic [BUS_W-1:0] data_i,
   output logic             cs_n_o,
   output logic             rc_o,
   output logic             hben_o,
   output logic             busy_o,
   output logic             valid_o,
   output logic             err_o,
   output logic [OUT_W-1:0] result_o
);

   localparam int RD_CYC = DV_CYC + SYNC_STAGES;
   localparam int MAXC   = max_of(max_of(max_of(WAKE_CYC, ACQ_CYC), max_of(CSL_CYC, CSH_CYC)),
                                  max_of(RD_CYC, EOC_TMO_CYC));
   localparam int TW     = $clog2(MAXC + 1);

   localparam logic [TW-1:0] L_CSL  = TW'(CSL_CYC - 1);
   localparam logic [TW-1:0] L_CSH  = TW'(CSH_CYC - 1);
   localparam logic [TW-1:0] L_ACQ  = TW'(ACQ_CYC - 1);
   localparam logic [TW-1:0] L_WAKE = TW'(WAKE_CYC - 1);
   localparam logic [TW-1:0] L_RD   = TW'(RD_CYC - 1);
   localparam logic [TW-1:0] L_TMO  = TW'(EOC_TMO_CYC - 1);

   if (CSL_CYC < 1 || CSH_CYC < 1 || ACQ_CYC < 1 || DV_CYC < 1) begin : g_bad_timing
      $error("adc_host_seq: timing parameters must be at least one cycle");
   end
   if (ACQ_CYC < CSH_CYC || WAKE_CYC < ACQ_CYC) begin : g_bad_gap
      $error("adc_host_seq: WAKE_CYC >= ACQ_CYC >= CSH_CYC required");
   end
   if (2 * RD_CYC < CSL_CYC) begin : g_bad_read
      $error("adc_host_seq: read phase shorter than chip-select low width");
   end
   if (OUT_W < RES_W) begin : g_bad_out
      $error("adc_host_seq: OUT_W must hold RES_W bits");
   end

   // input synchronizers
   logic             eoc_n_s;
   logic [BUS_W-1:0] data_s;

   adc_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_eoc (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (eoc_n_i),
      .q_o   (eoc_n_s)
   );

   adc_seq_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (data_i),
      .q_o   (data_s)
   );

   // shared phase timer
   logic          t_load;
   logic [TW-1:0] t_val;
   logic          t_exp;

   adc_seq_timer #(.TW(TW)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .expired_o  (t_exp)
   );

   // sequencer
   seq_state_t state_q, state_d;
   logic       mode_q;
   logic       asleep_q;
   logic       err_q;
   logic       cap_hi, cap_lo;
   logic       tmo_hit;
   logic       accept;

   assign accept  = (state_q == ST_IDLE) && start_i;
   assign tmo_hit = (state_q == ST_CONV_WAIT) && eoc_n_s && t_exp;

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      cap_hi  = 1'b0;
      cap_lo  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_WAKE_LO;
               t_load  = 1'b1;
               t_val   = L_CSL;
            end
         end
         ST_WAKE_LO: begin
            if (t_exp) begin
               state_d = ST_ACQ;
               t_load  = 1'b1;
               t_val   = asleep_q ? L_WAKE : L_ACQ;
            end
         end
         ST_ACQ: begin
            if (t_exp) begin
               state_d = ST_CONV_LO;
               t_load  = 1'b1;
               t_val   = L_CSL;
            end
         end
         ST_CONV_LO: begin
            if (t_exp) begin
               state_d = ST_CONV_WAIT;
               t_load  = 1'b1;
               t_val   = L_TMO;
            end
         end
         ST_CONV_WAIT: begin
            if (!eoc_n_s) begin
               state_d = ST_RD_SETUP;
               t_load  = 1'b1;
               t_val   = L_CSH;
            end else if (t_exp) begin
               state_d = ST_IDLE;
            end
         end
         ST_RD_SETUP: begin
            if (t_exp) begin
               state_d = ST_RD_HI;
               t_load  = 1'b1;
               t_val   = L_RD;
            end
         end
         ST_RD_HI: begin
            if (t_exp) begin
               cap_hi  = 1'b1;
               state_d = ST_RD_LO;
               t_load  = 1'b1;
               t_val   = L_RD;
            end
         end
         ST_RD_LO: begin
            if (t_exp) begin
               cap_lo  = 1'b1;
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mode_q   <= 1'b0;
         asleep_q <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            mode_q <= shutdown_i;
            err_q  <= 1'b0;
         end
         if (state_q == ST_CONV_LO && t_exp) begin
            asleep_q <= mode_q;
         end
         if (tmo_hit) begin
            err_q    <= 1'b1;
            asleep_q <= 1'b1;
         end
      end
   end

   // registered pin outputs, decoded from the next state
   logic cs_n_q, rc_q, hben_q, busy_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_q  <= 1'b1;
         rc_q    <= 1'b0;
         hben_q  <= 1'b0;
         busy_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         cs_n_q  <= !(state_d inside {ST_WAKE_LO, ST_CONV_LO, ST_RD_HI, ST_RD_LO});
         if (state_d inside {ST_RD_SETUP, ST_RD_HI, ST_RD_LO}) begin
            rc_q <= 1'b1;
         end else if (state_d inside {ST_CONV_LO, ST_CONV_WAIT}) begin
            rc_q <= mode_q;
         end else begin
            rc_q <= 1'b0;
         end
         hben_q  <= state_d inside {ST_RD_SETUP, ST_RD_HI};
         busy_q  <= (state_d != ST_IDLE);
         valid_q <= (state_d == ST_DONE);
      end
   end

   adc_seq_pack #(.BUS_W(BUS_W), .RES_W(RES_W), .OUT_W(OUT_W)) i_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_hi_i (cap_hi),
      .cap_lo_i (cap_lo),
      .bus_i    (data_s),
      .word_o   (result_o)
   );

   assign cs_n_o  = cs_n_q;
   assign rc_o    = rc_q;
   assign hben_o  = hben_q;
   assign busy_o  = busy_q;
   assign valid_o = valid_q;
   assign err_o   = err_q;

endmodule

// File: rtl/adc_host_seq_chk.sv
module adc_host_seq_chk #(
   parameter int WAKE_CYC = 600_000,
   parameter int RES_W    = 14,
   parameter int OUT_W    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n_o,
   input logic             rc_o,
   input logic             hben_o,
   input logic             busy_o,
   input logic             valid_o,
   input logic             err_o,
   input logic [OUT_W-1:0] result_o
);

   logic       cs_prev;
   logic [1:0] edges;
   logic       sleep_m;
   int         gap;
   logic       cs_fall;

   assign cs_fall = cs_prev && !cs_n_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev <= 1'b1;
         edges   <= '0;
         sleep_m <= 1'b1;
         gap     <= 0;
      end else begin
         cs_prev <= cs_n_o;
         if (cs_fall) begin
            if (edges != 2'd3) edges <= edges + 1'b1;
         end else if (!busy_o) begin
            edges <= '0;
         end
         if (cs_fall && edges == 2'd1) sleep_m <= rc_o;
         if (err_o && !busy_o) sleep_m <= 1'b1;
         if (cs_fall && edges == 2'd0) gap <= 0;
         else if (gap < WAKE_CYC + 1) gap <= gap + 1;
      end
   end

   assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !hben_o && !valid_o));

   assert_first_edge_rc_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && edges == 2'd0) |-> !rc_o);

   assert_wake_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && edges == 2'd1 && sleep_m) |-> (gap >= WAKE_CYC));

   assert_read_edge_rc_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && edges == 2'd2) |-> rc_o);

   assert_read_high_byte_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && edges == 2'd2) |-> hben_o);

   assert_result_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (result_o[OUT_W-1:RES_W] == '0));

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_valid_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> busy_o);

   assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!busy_o && cs_n_o && !valid_o));

   assert_three_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |-> (edges != 2'd3));

endmodule

bind adc_host_seq adc_host_seq_chk #(
   .WAKE_CYC (WAKE_CYC),
   .RES_W    (RES_W),
   .OUT_W    (OUT_W)
) i_adc_host_seq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n_o   (cs_n_o),
   .rc_o     (rc_o),
   .hben_o   (hben_o),
   .busy_o   (busy_o),
   .valid_o  (valid_o),
   .err_o    (err_o),
   .result_o (result_o)
);

// File: tb/test_adc_host_seq.sv
module test_adc_host_seq;

   localparam int WAKE = 300;
   localparam int ACQ  = 20;
   localparam int CSL  = 4;
   localparam int CONV = 150;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        shutdown_i = 1'b0;
   logic        eoc_n_i = 1'b1;
   logic [7:0]  data_i;
   logic        cs_n_o, rc_o, hben_o, busy_o, valid_o, err_o;
   logic [15:0] result_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   adc_host_seq #(
      .CLK_HZ(50_000_000), .WAKE_CYC(WAKE), .ACQ_CYC(ACQ), .CSL_CYC(CSL),
      .CSH_CYC(4), .DV_CYC(3), .EOC_TMO_CYC(400)
   ) i_adc_host_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .shutdown_i(shutdown_i),
      .eoc_n_i(eoc_n_i), .data_i(data_i), .cs_n_o(cs_n_o), .rc_o(rc_o),
      .hben_o(hben_o), .busy_o(busy_o), .valid_o(valid_o), .err_o(err_o),
      .result_o(result_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // converter model
   logic [13:0] m_sample = '0;
   bit          m_no_eoc = 0;
   bit          m_exp_sd = 0;
   int          m_min_gap = 0, m_max_gap = 0;
   int          m_edges = 0, m_gap = 0, m_conv = 0;
   bit          m_gap_run = 0;
   logic        m_cs_prev = 1'b1;

   assign data_i = hben_o ? {2'b11, m_sample[13:8]} : m_sample[7:0];

   always @(negedge clk) begin
      if (m_gap_run) m_gap++;
      if (m_conv > 0) begin
         m_conv--;
         if (m_conv == 0) eoc_n_i <= 1'b0;
      end
      if (m_cs_prev && !cs_n_o) begin
         case (m_edges)
            0: begin
               chk(rc_o == 1'b0, "R2 rc at first edge", rc_o, 0);
               m_gap = 0;
               m_gap_run = 1;
            end
            1: begin
               chk(rc_o == m_exp_sd, "R3 rc at second edge", rc_o, m_exp_sd);
               chk(m_gap >= m_min_gap && m_gap <= m_max_gap, "R4/R5 acquisition gap", m_gap, m_min_gap);
               m_gap_run = 0;
               if (!m_no_eoc) m_conv = CONV;
            end
            2: begin
               chk(rc_o == 1'b1, "R6 rc at read edge", rc_o, 1);
               chk(eoc_n_i == 1'b0, "R6 read edge after eoc", eoc_n_i, 0);
               chk(hben_o == 1'b1, "R7 upper byte first", hben_o, 1);
               eoc_n_i <= 1'b1;
            end
            default: chk(0, "R10 extra chip-select edge", m_edges + 1, 3);
         endcase
         m_edges++;
      end
      m_cs_prev = cs_n_o;
   end

   bit tb_sleep = 1;

   task automatic pulse_start(input bit sd);
      @(negedge clk);
      shutdown_i = sd;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(cs_n_o == 1'b1, "R1 cs high at reset", cs_n_o, 1);
      chk({busy_o, valid_o, err_o, hben_o} == 4'b0, "R1 flags low at reset",
          {busy_o, valid_o, err_o, hben_o}, 0);
   endtask

   task automatic t_conv(input bit sd, input logic [13:0] val, input bit extra_start);
      int waited;
      m_edges = 0;
      m_sample = val;
      m_no_eoc = 0;
      m_exp_sd = sd;
      if (tb_sleep) begin
         m_min_gap = WAKE;
         m_max_gap = WAKE + CSL + 3;
      end else begin
         m_min_gap = CSL + ACQ - 1;
         m_max_gap = CSL + ACQ + 2;
      end
      pulse_start(sd);
      waited = 0;
      while (!valid_o && waited < 3000) begin
         if (extra_start && waited == 40) begin
            start_i = 1'b1;          // R10: request while busy
            @(negedge clk);
            start_i = 1'b0;
            waited++;
            continue;
         end
         @(negedge clk);
         waited++;
      end
      chk(valid_o == 1'b1, "R8 valid seen", valid_o, 1);
      chk(result_o == {2'b00, val}, "R7 assembled result", result_o, {2'b00, val});
      chk(busy_o == 1'b1, "R8 busy during valid", busy_o, 1);
      @(negedge clk);
      chk(valid_o == 1'b0, "R8 valid one cycle", valid_o, 0);
      chk(busy_o == 1'b0, "R8 busy low after valid", busy_o, 0);
      repeat (60) @(negedge clk);
      chk(m_edges == 3, "R10 three edges per transaction", m_edges, 3);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R1 idle after transaction", cs_n_o, 1);
      tb_sleep = sd;
   endtask

   task automatic t_timeout;
      int waited;
      m_edges = 0;
      m_no_eoc = 1;
      m_exp_sd = 0;
      m_min_gap = tb_sleep ? WAKE : CSL + ACQ - 1;
      m_max_gap = tb_sleep ? WAKE + CSL + 3 : CSL + ACQ + 2;
      pulse_start(0);
      waited = 0;
      while (!err_o && waited < 3000) begin
         chk(valid_o == 1'b0, "R9 no valid on timeout", valid_o, 0);
         @(negedge clk);
         waited++;
      end
      chk(err_o == 1'b1, "R9 error raised", err_o, 1);
      chk(busy_o == 1'b0 && cs_n_o == 1'b1, "R9 idle after timeout", {busy_o, cs_n_o}, 1);
      chk(m_edges == 2, "R9 no read edge", m_edges, 2);
      repeat (10) @(negedge clk);
      m_no_eoc = 0;
      tb_sleep = 1;
      pulse_start(1);
      chk(err_o == 1'b0, "R9 error cleared by start", err_o, 0);
      m_edges = 0;
      m_exp_sd = 1;
      m_sample = 14'h0155;
      m_min_gap = WAKE;
      m_max_gap = WAKE + CSL + 3;
      while (!valid_o && waited < 6000) begin
         @(negedge clk);
         waited++;
      end
      chk(result_o == 16'h0155, "R4 wake after timeout result", result_o, 16'h0155);
      repeat (60) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_conv(1, 14'h3FFF, 0);   // R4 from reset, ends in shutdown
      t_conv(0, 14'h0000, 0);   // R4 after shutdown, ends in standby
      t_conv(0, 14'h2A5C, 1);   // R5 short gap, R10 extra start
      t_conv(1, 14'h1234, 0);   // R5 short gap, ends in shutdown
      t_conv(0, 14'h00FF, 0);   // R4 long gap again
      t_timeout();              // R9
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule